// File: doc/BRIEF.md
# Tagged-Entry FIFO Word Packer

This block sits between a 32-bit register port and a byte-serial bus engine that works on 16-bit tagged entries. Each entry carries one data byte in bits 7:0 and an 8-bit tag in bits 15:8. On the transmit side, software writes 32-bit words that each hold two entries. The block unpacks them into an entry FIFO, and the bus engine pops that FIFO one entry at a time. On the receive side, the engine hands over bytes one by one. The block gathers them two per word into a small word FIFO that software reads.

Software first programs how many entries it will send, or how many bytes it expects to receive. The block then takes over from there:

- When only one transmit entry remains, it takes just the low half of the next written word.
- Once a count is exhausted, it stops accepting data on that path.
- It raises done flags when the programmed work is complete.
- It raises a service flag when the transmit FIFO has drained to half while entries are still owed.
- It sets a sticky overrun flag when a write finds too little room, and drops that write.

The FIFO is sized in raw byte slots. Because every byte travels with its tag, it holds only half that many entries.

Top module: `tag_word_packer`

## Requirements
- R1: After reset, `status` is all zero, `ent_valid` and `rd_valid` are low and `rx_ready` is low.
- R2: A word accepted while two or more entries remain pushes `wr_data[15:0]` first and `wr_data[31:16]` second, unchanged (tag in 15:8, data in 7:0).
- R3: A word accepted while exactly one entry remains pushes only `wr_data[15:0]`; the upper half is ignored.
- R4: The entry FIFO holds RAW_SLOTS/2 entries; `status[6]` (full) is set while fewer than two entry slots are free.
- R5: A write that needs more free slots than are available is dropped whole and sets `status[2]` (overrun), which stays set until the next `cfg_out_we`.
- R6: Writes arriving after the transmit count has reached zero push nothing.
- R7: `ent_valid` and `status[4]` are high exactly when the entry FIFO is not empty; `ent_data` shows the oldest entry.
- R8: `status[8]` (transmit service) is high while the FIFO holds at most half its entry capacity and entries remain to be written.
- R9: `status[10]` (transmit done) is high once every entry of the programmed count has been popped, and holds until reprogrammed.
- R10: Received bytes are packed with the first byte in bits 7:0 and the second in bits 23:16, other bits zero; a final odd byte forms a word by itself in bits 7:0.
- R11: `rd_valid` and `status[5]` show a non-empty receive FIFO. `status[11]` (receive done) is high once the programmed byte count has been received. `rx_ready` is low while no bytes are owed.
- R12: `rx_ready` is low while the receive word FIFO is full, so no byte is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_out_we | input | 1 | Load transmit entry count, clear entry FIFO and overrun |
| cfg_in_we | input | 1 | Load receive byte count, clear word FIFO |
| cfg_cnt | input | CNT_W | Count value for either load |
| wr_en | input | 1 | Register-port write of a packed entry pair |
| wr_data | input | 32 | Two entries, first in low half |
| ent_valid | output | 1 | Entry FIFO has an entry |
| ent_data | output | 16 | Oldest entry |
| ent_pop | input | 1 | Bus engine takes the oldest entry |
| rx_valid | input | 1 | Received byte offered |
| rx_byte | input | 8 | Received byte |
| rx_ready | output | 1 | Byte is taken this cycle if offered |
| rd_en | input | 1 | Register-port read pops a word |
| rd_valid | output | 1 | Receive word FIFO has a word |
| rd_data | output | 32 | Oldest received word |
| status | output | 12 | Flags: 2 overrun, 4 tx not empty, 5 rx not empty, 6 tx full, 8 tx service, 10 tx done, 11 rx done |

## Verification
The hardest situation to reach is an overrun that occurs while entries are still owed and the FIFO is nearly full. This needs writes to outpace pops for many cycles without the count running out first. The directed part gets there by programming a count larger than the capacity and writing without popping until a write is refused. A fixed-seed random phase then reprograms counts often and skews write and pop rates, so that odd tails and full-FIFO writes coincide. The odd final transmit entry and the odd final receive byte are each also hit directly.

// File: rtl/tag_word_packer.sv
module tag_word_packer #(
  parameter int RAW_SLOTS = 32,
  parameter int IN_DEPTH  = 4,
  parameter int CNT_W     = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_out_we,
  input  logic             cfg_in_we,
  input  logic [CNT_W-1:0] cfg_cnt,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  output logic             ent_valid,
  output logic [15:0]      ent_data,
  input  logic             ent_pop,
  input  logic             rx_valid,
  input  logic [7:0]       rx_byte,
  output logic             rx_ready,
  input  logic             rd_en,
  output logic             rd_valid,
  output logic [31:0]      rd_data,
  output logic [11:0]      status
);
  localparam int DEPTH = RAW_SLOTS / 2;
  localparam int AW    = $clog2(DEPTH);
  localparam int IAW   = $clog2(IN_DEPTH);
  localparam logic [AW:0]  DEPTH_L = (AW+1)'(DEPTH);
  localparam logic [AW:0]  HALF_L  = (AW+1)'(DEPTH / 2);
  localparam logic [IAW:0] IN_L    = (IAW+1)'(IN_DEPTH);

  // transmit side
  logic [15:0]      omem [DEPTH];
  logic [AW-1:0]    owp, orp;
  logic [AW:0]      olvl;
  logic [CNT_W-1:0] oleft, opend;
  logic             ovr, oarm;
  logic [1:0]       need;
  logic [AW:0]      ofree;
  logic             wr_try, wr_ok, pop_ok;

  assign need   = (oleft > CNT_W'(1)) ? 2'd2 : {1'b0, oleft != '0};
  assign ofree  = DEPTH_L - olvl;
  assign wr_try = wr_en && need != 2'd0;
  assign wr_ok  = wr_try && ofree >= (AW+1)'(need);
  assign pop_ok = ent_pop && olvl != '0;

  assign ent_valid = olvl != '0;
  assign ent_data  = omem[orp];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owp <= '0; orp <= '0; olvl <= '0;
      oleft <= '0; opend <= '0; ovr <= 1'b0; oarm <= 1'b0;
    end else if (cfg_out_we) begin
      owp <= '0; orp <= '0; olvl <= '0;
      oleft <= cfg_cnt; opend <= cfg_cnt; ovr <= 1'b0; oarm <= 1'b1;
    end else begin
      if (wr_ok) begin
        owp   <= owp + AW'(need);
        oleft <= oleft - CNT_W'(need);
      end
      if (wr_try && !wr_ok) ovr <= 1'b1;
      if (pop_ok) begin
        orp   <= orp + AW'(1);
        opend <= opend - CNT_W'(1);
      end
      olvl <= olvl + (AW+1)'(wr_ok ? need : 2'd0) - (AW+1)'(pop_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && !cfg_out_we && wr_ok) begin
      omem[owp] <= wr_data[15:0];
      if (need == 2'd2) omem[owp + AW'(1)] <= wr_data[31:16];
    end
  end

  // receive side
  logic [31:0]      imem [IN_DEPTH];
  logic [IAW-1:0]   iwp, irp;
  logic [IAW:0]     ilvl;
  logic [CNT_W-1:0] ileft;
  logic             iph, iarm;
  logic [7:0]       ilo;
  logic             rx_ok, commit, rd_ok;
  logic [31:0]      cword;

  assign rx_ready = ileft != '0 && ilvl != IN_L;
  assign rx_ok    = rx_valid && rx_ready;
  assign commit   = rx_ok && (iph || ileft == CNT_W'(1));
  assign cword    = iph ? {8'h00, rx_byte, 8'h00, ilo} : {24'h0, rx_byte};
  assign rd_ok    = rd_en && ilvl != '0;
  assign rd_valid = ilvl != '0;
  assign rd_data  = imem[irp];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iwp <= '0; irp <= '0; ilvl <= '0; ileft <= '0;
      iph <= 1'b0; iarm <= 1'b0; ilo <= '0;
    end else if (cfg_in_we) begin
      iwp <= '0; irp <= '0; ilvl <= '0; ileft <= cfg_cnt;
      iph <= 1'b0; iarm <= 1'b1;
    end else begin
      if (rx_ok) begin
        ileft <= ileft - CNT_W'(1);
        iph   <= !commit;
        if (!iph) ilo <= rx_byte;
      end
      if (commit) iwp <= iwp + IAW'(1);
      if (rd_ok)  irp <= irp + IAW'(1);
      ilvl <= ilvl + (IAW+1)'(commit) - (IAW+1)'(rd_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && !cfg_in_we && commit) imem[iwp] <= cword;
  end

  assign status = {iarm && ileft == '0, oarm && opend == '0, 1'b0,
                   olvl <= HALF_L && oleft != '0, 1'b0, ofree < (AW+1)'(2),
                   ilvl != '0, olvl != '0, 1'b0, ovr, 2'b00};

  p_lvl_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    olvl <= DEPTH_L);
  p_drop_keeps_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_try && !wr_ok && !pop_ok && !cfg_out_we) |=> $stable(olvl));
  p_ovr_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (status[2] && !cfg_out_we) |=> status[2]);
  p_exhausted_no_push_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (oleft == '0 && !cfg_out_we && !pop_ok) |=> $stable(olvl));
  p_odd_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && oleft == CNT_W'(1) && !pop_ok && !cfg_out_we) |=> olvl == $past(olvl) + (AW+1)'(1));
  p_done_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (status[10] && !cfg_out_we) |=> status[10]);
  p_in_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ilvl <= IN_L);
  p_full_no_take_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ilvl == IN_L && !rd_ok && !cfg_in_we) |=> $stable(ileft));
endmodule

// File: tb/tag_word_packer_bench.sv
module tag_word_packer_bench;
  localparam int CLK_P = 10;
  localparam int RAW = 32;
  localparam int DEPTH = RAW / 2;
  localparam int IND = 4;

  logic clk = 0, rst_n = 0;
  logic cfg_out_we = 0, cfg_in_we = 0, wr_en = 0, ent_pop = 0, rx_valid = 0, rd_en = 0;
  logic [8:0] cfg_cnt = 0;
  logic [31:0] wr_data = 0;
  logic [7:0] rx_byte = 0;
  logic ent_valid, rx_ready, rd_valid;
  logic [15:0] ent_data;
  logic [31:0] rd_data;
  logic [11:0] status;

  always #(CLK_P/2) clk = ~clk;

  tag_word_packer #(.RAW_SLOTS(RAW), .IN_DEPTH(IND), .CNT_W(9)) u_tag_word_packer (
    .clk, .rst_n, .cfg_out_we, .cfg_in_we, .cfg_cnt, .wr_en, .wr_data,
    .ent_valid, .ent_data, .ent_pop, .rx_valid, .rx_byte, .rx_ready,
    .rd_en, .rd_valid, .rd_data, .status);

  int checks = 0, fails = 0, cyc = 0;
  logic [15:0] oq[$];
  logic [31:0] iq[$];
  int ml = 0, mp = 0, il = 0;
  bit movr = 0, marmo = 0, marmi = 0, mph = 0;
  logic [7:0] mlo = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL R1 watchdog actual=%0d expected<%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] exp_status();
    logic [11:0] s = '0;
    s[2] = movr;
    s[4] = oq.size() != 0;
    s[5] = iq.size() != 0;
    s[6] = (DEPTH - oq.size()) < 2;
    s[8] = oq.size() <= DEPTH/2 && ml != 0;
    s[10] = marmo && mp == 0;
    s[11] = marmi && il == 0;
    return s;
  endfunction

  task automatic compare();
    logic [11:0] s = exp_status();
    chk("R7 ent_valid", 32'(ent_valid), 32'(oq.size() != 0));
    if (oq.size() != 0) chk("R2 ent_data", 32'(ent_data), 32'(oq[0]));
    chk("R5 overrun", 32'(status[2]), 32'(s[2]));
    chk("R7 tx_not_empty", 32'(status[4]), 32'(s[4]));
    chk("R11 rx_not_empty", 32'(status[5]), 32'(s[5]));
    chk("R4 full", 32'(status[6]), 32'(s[6]));
    chk("R8 service", 32'(status[8]), 32'(s[8]));
    chk("R9 tx_done", 32'(status[10]), 32'(s[10]));
    chk("R11 rx_done", 32'(status[11]), 32'(s[11]));
    chk("R11 rd_valid", 32'(rd_valid), 32'(iq.size() != 0));
    if (iq.size() != 0) chk("R10 rd_data", rd_data, iq[0]);
    chk("R12 rx_ready", 32'(rx_ready), 32'(il != 0 && iq.size() < IND));
  endtask

  task automatic step(bit co, bit ci, int cnt, bit w, logic [31:0] wd, bit p,
                      bit rv, logic [7:0] rb, bit rd);
    cfg_out_we = co; cfg_in_we = ci; cfg_cnt = 9'(cnt); wr_en = w; wr_data = wd;
    ent_pop = p; rx_valid = rv; rx_byte = rb; rd_en = rd;
    if (co) begin
      ml = cnt; mp = cnt; oq.delete(); movr = 0; marmo = 1;
    end else begin
      int need = ml > 1 ? 2 : ml;
      bit ok = w && need > 0 && (DEPTH - oq.size()) >= need;
      if (w && need > 0 && !ok) movr = 1;
      if (p && oq.size() > 0) begin void'(oq.pop_front()); mp--; end
      if (ok) begin
        oq.push_back(wd[15:0]);
        if (need == 2) oq.push_back(wd[31:16]);
        ml -= need;
      end
    end
    if (ci) begin
      il = cnt; iq.delete(); mph = 0; marmi = 1;
    end else begin
      bit rdy = il != 0 && iq.size() < IND;
      if (rd && iq.size() > 0) void'(iq.pop_front());
      if (rv && rdy) begin
        if (mph) begin iq.push_back({8'h00, rb, 8'h00, mlo}); mph = 0; end
        else if (il == 1) iq.push_back({24'h0, rb});
        else begin mlo = rb; mph = 1; end
        il--;
      end
    end
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic idle();               step(0,0,0,0,0,0,0,0,0); endtask
  task automatic wr(logic [31:0] d);   step(0,0,0,1,d,0,0,0,0); endtask
  task automatic cfgo(int n);          step(1,0,n,0,0,0,0,0,0); endtask
  task automatic cfgi(int n);          step(0,1,n,0,0,0,0,0,0); endtask
  task automatic rx(logic [7:0] b);    step(0,0,0,0,0,0,1,b,0); endtask

  task automatic drain(string req, int exp_n);
    int n = 0;
    while (ent_valid && n < 64) begin step(0,0,0,0,0,1,0,0,0); n++; end
    chk(req, 32'(n), 32'(exp_n));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 status", 32'(status), 32'h0);
    chk("R1 ent_valid", 32'(ent_valid), 32'h0);
    chk("R1 rd_valid", 32'(rd_valid), 32'h0);
    chk("R1 rx_ready", 32'(rx_ready), 32'h0);

    cfgo(5);
    wr(32'h0222_0111);
    chk("R2 first entry low half", 32'(ent_data), 32'h0111);
    wr(32'h0444_0333);
    wr(32'hDEAD_0355);
    drain("R3 odd tail count", 5);
    chk("R9 done after drain", 32'(status[10]), 32'h1);
    wr(32'h0777_0666);
    chk("R6 no push after count", 32'(ent_valid), 32'h0);

    cfgo(40);
    for (int k = 0; k < 8; k++) wr({16'h0200 | 16'(2*k+1), 16'h0200 | 16'(2*k)});
    chk("R4 full flag", 32'(status[6]), 32'h1);
    wr(32'h0999_0888);
    chk("R5 overrun set", 32'(status[2]), 32'h1);
    drain("R4 capacity", DEPTH);
    chk("R5 overrun sticky", 32'(status[2]), 32'h1);

    cfgi(5);
    rx(8'h11); rx(8'h22); rx(8'h33); rx(8'h44); rx(8'h55);
    chk("R10 first word", rd_data, 32'h0022_0011);
    chk("R11 rx done", 32'(status[11]), 32'h1);
    chk("R11 rx_ready idle", 32'(rx_ready), 32'h0);
    step(0,0,0,0,0,0,0,0,1);
    step(0,0,0,0,0,0,0,0,1);
    chk("R10 odd byte word", rd_data, 32'h0000_0055);
    step(0,0,0,0,0,0,0,0,1);

    cfgi(20);
    for (int k = 0; k < 9; k++) rx(8'(k + 8'hA0));
    chk("R12 ready low when full", 32'(rx_ready), 32'h0);

    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 199);
      if (r == 0) step(1,0,$urandom_range(0,40),0,0,0,0,0,0);
      else if (r == 1) step(0,1,$urandom_range(0,40),0,0,0,0,0,0);
      else step(0,0,0,$urandom_range(0,2) != 0,$urandom,$urandom_range(0,3) == 0,
                $urandom_range(0,1) == 1,8'($urandom),$urandom_range(0,2) == 0);
    end
    idle();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule